// File: doc/BRIEF.md
# Supply Supervisor and Watchdog Reset Controller

This block drives the reset line of a processor from three causes: the supply coming up, the supply sagging (brown-out), and a watchdog input that has stopped changing level. A supply-good flag comes in from an external comparator. While that flag is low, reset is held. Once it goes high, reset stays asserted for a fixed pulse width and then releases. While the processor runs, it must keep changing the level of the watchdog input. If the input holds one level for longer than the timeout, the block issues a reset pulse of the same fixed width. A separate flag marks the watchdog input as left floating, and that counts as servicing.

Both intervals are parameters in clock cycles, so the same design covers a 200 ms pulse with a 1.6 s timeout at the real clock and also short values for a test bench. The supply flag, the watchdog input and the floating flag all pass through two-flop synchronizers before any logic looks at them. One internal reset state feeds an active-low output and an active-high output. An asynchronous clear of the controller itself puts the block into the supply-low hold state.

Top module: `sup_rst_wdog`

## Requirements
- R1: Let E be the first clock edge that samples supply_ok high. Reset releases exactly PULSE_CYC+2 cycles after E: two cycles of synchronizer delay, then a pulse of PULSE_CYC cycles. Every assertion of reset lasts at least PULSE_CYC cycles.
- R2: Reset is asserted at the second clock edge after the edge that first samples supply_ok low. It stays asserted for as long as supply_ok is low. When supply_ok returns high, the release follows the R1 timing.
- R3: rst_out_n is always the logical inverse of rst_out. rst_out = 1 means reset is asserted.
- R4: Suppose wd_in holds one level and wd_float is 0. Reset then asserts after exactly TIMEOUT_CYC consecutive cycles out of reset.
- R5: A rising or falling change of the synchronized wd_in services the watchdog and restarts the interval. If the changes come no more than TIMEOUT_CYC cycles apart, reset never asserts. If they come TIMEOUT_CYC+1 cycles apart, reset asserts.
- R6: While wd_float is 1, the watchdog is treated as serviced on every cycle, so it never times out, whatever wd_in does.
- R7: With wd_in stuck and wd_float at 0, reset repeats with a period of exactly PULSE_CYC+TIMEOUT_CYC cycles. It is asserted for PULSE_CYC cycles and released for TIMEOUT_CYC cycles.
- R8: The watchdog count is held at zero whenever reset is asserted, whatever the cause. Each release from reset therefore starts a full TIMEOUT_CYC interval.
- R9: While arst_n is low, reset is asserted at once. After arst_n rises, the block is in the hold state, and it releases only after the timing of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| arst_n | input | 1 | Asynchronous active-low clear of the controller |
| supply_ok | input | 1 | Comparator flag, 1 when the supply is above threshold |
| wd_in | input | 1 | Watchdog service input; any level change services it |
| wd_float | input | 1 | 1 when the watchdog input is left floating (counts as service) |
| rst_out_n | output | 1 | Processor reset, active low |
| rst_out | output | 1 | Processor reset, active high |

## Verification
The watchdog is driven with service toggles at periods of 3, T/2, T−1, T and T+1 cycles. This shows that the boundary lies exactly at the timeout: a period of T passes and T+1 fires. It also shows that rising and falling edges count alike. A stuck input with the floating flag clear, a stuck input with the flag set, and a too-slow toggle with the flag set show that the flag overrides an input that would otherwise expire. Supply rise, a long brown-out with a stuck input, and a controller clear in the middle of a run each give an exact count of cycles to release. The brown-out case shows that the timer restarts from zero and does not carry stale time across a reset.

// File: rtl/sup_rst_pkg.sv
package sup_rst_pkg;

    // Supervisor reset state
    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,   // supply below threshold, reset held
        ST_PULSE = 2'd1,   // supply good, timing the reset pulse
        ST_RUN   = 2'd2    // reset released, watchdog active
    } sv_state_e;

    localparam int unsigned SYNC_STAGES = 2;

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    assign stg_d[0] = din;

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        assign stg_d[i] = stg_q[i-1];
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
        end else begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
        end
    end

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/sup_wd_timer.sv
module sup_wd_timer #(
    parameter int unsigned TIMEOUT_CYC = 80_000_000,
    localparam int unsigned TCW        = $clog2(TIMEOUT_CYC + 1)
) (
    input  logic           clk,
    input  logic           arst_n,
    input  logic           wd_s,       // synchronized watchdog level
    input  logic           float_s,    // synchronized floating flag
    input  logic           run,        // reset currently released
    input  logic           sup_s,      // synchronized supply-good
    output logic           expire,     // timeout reached this cycle
    output logic           service,    // serviced this cycle
    output logic [TCW-1:0] cnt
);

    typedef struct packed {
        logic           prev;
        logic [TCW-1:0] cnt;
    } wd_reg_t;

    localparam logic [TCW-1:0] LAST = TCW'(TIMEOUT_CYC - 1);

    wd_reg_t r_d, r_q;
    logic    expire_d;

    always_comb begin
        r_d      = r_q;
        expire_d = 1'b0;
        service  = (wd_s ^ r_q.prev) | float_s;
        r_d.prev = wd_s;
        if (!run || !sup_s) begin
            r_d.cnt = '0;
        end else if (service) begin
            r_d.cnt = '0;
        end else if (r_q.cnt == LAST) begin
            r_d.cnt  = '0;
            expire_d = 1'b1;
        end else begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) r_q <= '0;
        else         r_q <= r_d;
    end

    assign expire = expire_d;
    assign cnt    = r_q.cnt;

endmodule

// File: rtl/sup_pulse_ctl.sv
module sup_pulse_ctl
    import sup_rst_pkg::*;
#(
    parameter int unsigned PULSE_CYC = 10_000_000,
    localparam int unsigned PCW      = $clog2(PULSE_CYC + 1)
) (
    input  logic clk,
    input  logic arst_n,
    input  logic sup_s,
    input  logic wd_expire,
    output logic rst_assert
);

    typedef struct packed {
        sv_state_e      st;
        logic [PCW-1:0] cnt;
    } pc_reg_t;

    localparam logic [PCW-1:0] LAST = PCW'(PULSE_CYC - 1);

    pc_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_HOLD: begin
                r_d.cnt = '0;
                if (sup_s) r_d.st = ST_PULSE;
            end
            ST_PULSE: begin
                if (r_q.cnt == LAST) begin
                    r_d.st  = ST_RUN;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_RUN: begin
                r_d.cnt = '0;
                if (wd_expire) r_d.st = ST_PULSE;
            end
            default: begin
                r_d.st  = ST_HOLD;
                r_d.cnt = '0;
            end
        endcase
        // brown-out overrides every state
        if (!sup_s) begin
            r_d.st  = ST_HOLD;
            r_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) r_q <= '{st: ST_HOLD, cnt: '0};
        else         r_q <= r_d;
    end

    assign rst_assert = (r_q.st != ST_RUN);

endmodule

// File: rtl/sup_rst_wdog.sv
module sup_rst_wdog
    import sup_rst_pkg::*;
#(
    parameter int unsigned PULSE_CYC   = 10_000_000,
    parameter int unsigned TIMEOUT_CYC = 80_000_000,
    localparam int unsigned TCW        = $clog2(TIMEOUT_CYC + 1)
) (
    input  logic clk,
    input  logic arst_n,
    input  logic supply_ok,
    input  logic wd_in,
    input  logic wd_float,
    output logic rst_out_n,
    output logic rst_out
);

    logic [2:0]     raw_vec;
    logic [2:0]     syn_vec;
    logic           sup_s;
    logic           wd_s;
    logic           float_s;
    logic           run;
    logic           wd_expire;
    logic           wd_service;
    logic [TCW-1:0] wd_cnt;
    logic           rst_assert;

    assign raw_vec = {wd_float, wd_in, supply_ok};

    sup_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .arst_n (arst_n),
        .din    (raw_vec),
        .dout   (syn_vec)
    );

    assign sup_s   = syn_vec[0];
    assign wd_s    = syn_vec[1];
    assign float_s = syn_vec[2];

    sup_wd_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_wd (
        .clk     (clk),
        .arst_n  (arst_n),
        .wd_s    (wd_s),
        .float_s (float_s),
        .run     (run),
        .sup_s   (sup_s),
        .expire  (wd_expire),
        .service (wd_service),
        .cnt     (wd_cnt)
    );

    sup_pulse_ctl #(.PULSE_CYC(PULSE_CYC)) u_pc (
        .clk        (clk),
        .arst_n     (arst_n),
        .sup_s      (sup_s),
        .wd_expire  (wd_expire),
        .rst_assert (rst_assert)
    );

    assign run       = !rst_assert;
    assign rst_out   = rst_assert;
    assign rst_out_n = !rst_assert;

endmodule

// File: rtl/sup_rst_wdog_chk.sv
module sup_rst_wdog_chk #(
    parameter int unsigned PULSE_CYC   = 10_000_000,
    parameter int unsigned TIMEOUT_CYC = 80_000_000,
    localparam int unsigned TCW        = $clog2(TIMEOUT_CYC + 1)
) (
    input logic           clk,
    input logic           arst_n,
    input logic           rst_out,
    input logic           rst_out_n,
    input logic           sup_s,
    input logic           service,
    input logic           run,
    input logic [TCW-1:0] wd_cnt
);

    int unsigned asrt_len;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)      asrt_len <= 0;
        else if (rst_out) asrt_len <= (asrt_len < PULSE_CYC) ? asrt_len + 1 : asrt_len;
        else              asrt_len <= 0;
    end

    AST_POLARITY: assert property (@(posedge clk) disable iff (!arst_n)
        rst_out_n == !rst_out); // R3

    AST_PULSE_MIN: assert property (@(posedge clk) disable iff (!arst_n)
        (!rst_out && asrt_len != 0) |-> asrt_len >= PULSE_CYC); // R1

    AST_BROWNOUT_HOLD: assert property (@(posedge clk) disable iff (!arst_n)
        !sup_s |=> rst_out); // R2

    AST_TIMEOUT_FIRE: assert property (@(posedge clk) disable iff (!arst_n)
        (run && sup_s && !service && wd_cnt == TCW'(TIMEOUT_CYC - 1)) |=> rst_out); // R4

    AST_SERVICE_CLEAR: assert property (@(posedge clk) disable iff (!arst_n)
        (run && service) |=> wd_cnt == '0); // R5

    AST_FROZEN_IN_RESET: assert property (@(posedge clk) disable iff (!arst_n)
        rst_out |-> wd_cnt == '0); // R8

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!arst_n)
        wd_cnt < TCW'(TIMEOUT_CYC)); // R4

endmodule

bind sup_rst_wdog sup_rst_wdog_chk #(
    .PULSE_CYC   (PULSE_CYC),
    .TIMEOUT_CYC (TIMEOUT_CYC)
) chk_i (
    .clk       (clk),
    .arst_n    (arst_n),
    .rst_out   (rst_out),
    .rst_out_n (rst_out_n),
    .sup_s     (sup_s),
    .service   (wd_service),
    .run       (run),
    .wd_cnt    (wd_cnt)
);

// File: tb/sup_rst_wdog_tb_top.sv
`timescale 1ns/1ps
module sup_rst_wdog_tb_top;

    localparam int P = 20;
    localparam int T = 40;

    typedef struct packed {
        int   gap;    // toggle period in cycles, 0 = held
        logic flt;    // floating flag
        logic fire;   // reset expected within window
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{gap: T/2,   flt: 1'b0, fire: 1'b0},  // R5
        '{gap: T-1,   flt: 1'b0, fire: 1'b0},  // R5
        '{gap: T,     flt: 1'b0, fire: 1'b0},  // R5 boundary pass
        '{gap: T+1,   flt: 1'b0, fire: 1'b1},  // R5 boundary fire
        '{gap: 0,     flt: 1'b0, fire: 1'b1},  // R4 held level
        '{gap: 0,     flt: 1'b1, fire: 1'b0},  // R6 floating
        '{gap: T+5,   flt: 1'b1, fire: 1'b0},  // R6 floating overrides slow toggle
        '{gap: 3,     flt: 1'b0, fire: 1'b0}   // R5 fast toggle
    };

    logic clk = 1'b0;
    logic arst_n;
    logic supply_ok;
    logic wd_in;
    logic wd_float;
    logic rst_out_n;
    logic rst_out;

    int checks = 0;
    int errors = 0;
    logic pol_bad = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    sup_rst_wdog #(.PULSE_CYC(P), .TIMEOUT_CYC(T)) dut_i (
        .clk       (clk),
        .arst_n    (arst_n),
        .supply_ok (supply_ok),
        .wd_in     (wd_in),
        .wd_float  (wd_float),
        .rst_out_n (rst_out_n),
        .rst_out   (rst_out)
    );

    always @(negedge clk) if (arst_n && (rst_out_n !== ~rst_out)) pol_bad = 1'b1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // edges counted from the first one that samples the new supply level
    task automatic edges_until(input logic lvl, output int n);
        n = 0;
        do begin
            @(posedge clk); n++;
            @(negedge clk);
        end while (rst_out_n != lvl && n < 10000);
    endtask

    // negedges on which rst_out_n stays at lvl
    task automatic level_len(input logic lvl, output int n);
        n = 0;
        while (rst_out_n == lvl && n < 10000) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        int bad;
        arst_n = 1'b0; supply_ok = 1'b0; wd_in = 1'b0; wd_float = 1'b0;
        #1;
        check(rst_out == 1'b1 && rst_out_n == 1'b0, "R9 reset state", rst_out, 1);

        @(negedge clk); arst_n = 1'b1;
        repeat (6) @(negedge clk);
        check(rst_out == 1'b1, "R9 held without supply", rst_out, 1);

        // power-up
        supply_ok = 1'b1;
        edges_until(1'b1, n);
        check(n == P + 3, "R1 power-up release edges", n, P + 3);

        // stuck input: timeout, pulse, fresh interval
        level_len(1'b1, n);
        check(n == T, "R4 timeout length", n, T);
        level_len(1'b0, n);
        check(n == P, "R7 watchdog pulse width", n, P);
        level_len(1'b1, n);
        check(n == T, "R7 repeat run length", n, T);
        level_len(1'b0, n);

        // brown-out in run
        while (rst_out_n == 1'b0) @(negedge clk);
        repeat (5) @(negedge clk);
        supply_ok = 1'b0;
        edges_until(1'b0, n);
        check(n == 3, "R2 brown-out assert edges", n, 3);
        bad = 0;
        for (int i = 0; i < 3 * T; i++) begin
            @(negedge clk);
            if (rst_out_n) bad++;
        end
        check(bad == 0, "R2 held during brown-out", bad, 0);
        supply_ok = 1'b1;
        edges_until(1'b1, n);
        check(n == P + 3, "R2 release after brown-out", n, P + 3);
        level_len(1'b1, n);
        check(n == T, "R8 full interval after long reset", n, T);

        // controller clear in mid-run
        wd_float = 1'b1;
        while (rst_out_n == 1'b0) @(negedge clk);
        repeat (7) @(negedge clk);
        arst_n = 1'b0;
        #1;
        check(rst_out == 1'b1, "R9 clear asserts at once", rst_out, 1);
        @(negedge clk); arst_n = 1'b1;
        edges_until(1'b1, n);
        check(n == P + 3, "R9 release after clear", n, P + 3);

        // table walk
        for (int v = 0; v < NV; v++) begin
            int  tc;
            bit  released;
            bit  fired;
            supply_ok = 1'b0;
            wd_in     = 1'b0;
            wd_float  = VEC[v].flt;
            repeat (4) @(negedge clk);
            supply_ok = 1'b1;
            tc = 0; released = 1'b0; fired = 1'b0;
            for (int c = 0; c < P + 10 + 5 * T; c++) begin
                @(negedge clk);
                if (rst_out_n) released = 1'b1;
                else if (released) fired = 1'b1;
                if (VEC[v].gap > 0) begin
                    tc++;
                    if (tc == VEC[v].gap) begin
                        wd_in = ~wd_in;
                        tc = 0;
                    end
                end
            end
            check(released == 1'b1, $sformatf("R1 vector %0d released", v), released, 1);
            check(fired == VEC[v].fire,
                  $sformatf("R5/R6 vector %0d gap %0d float %0d", v, VEC[v].gap, VEC[v].flt),
                  fired, VEC[v].fire);
        end

        check(pol_bad == 1'b0, "R3 outputs complementary", pol_bad, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule